// File: doc/BRIEF.md
# Time-Slot Interchanger Host Control Port

This block is the processor side of a time-slot interchanger. An 8-bit host bus with a 2-bit register index reaches four registers: a control/status register, a slot register, a mode register and an indirect data register. The control register holds four output controls: the active data page, the backplane bus drive enable, the local bus drive enable and the local clock enable. It also takes three command bits. Each command bit returns a single-cycle pulse and then clears itself. Read data is registered. It appears on the cycle after the read strobe.

The slot and mode registers together form the address into a large internal memory space, with mode as the upper half and slot as the lower half. Neither can be read back. An access to the data register starts one transfer on a request/acknowledge memory port. A write sends the written byte. A read fetches a word into the data register. While a transfer is outstanding the busy bit is high and further data-register accesses are dropped. A software master reset returns every register to zero, drops any outstanding request, and leaves all drive enables off.

Top module: `tsi_host_port`

## Requirements
- R1: While `rst_n` is low every output is 0, including `host_rdata`, the memory request and all enables.
- R2: Register index 0 is control/status, 1 is slot, 2 is mode and 3 is data. A read strobe at a clock edge loads `host_rdata` at that edge. Reading index 1 or 2 gives 0. Reading index 0 gives {master-reset, clock-error-clear, system-error-clear, page, backplane-enable, local-bus-enable, local-clock-enable, busy} from bit 7 down to bit 0.
- R3: A control write loads `page_sel`, `bb_oe`, `lb_oe` and `lclk_oe` from data bits 4, 3, 2 and 1. The outputs change at the write edge, and only a control write or a master reset changes them.
- R4: Control data bit 6 drives `clkerr_clr` and bit 5 drives `syserr_clr`. Each is high for exactly the one cycle after the write and reads back 0 afterwards.
- R5: Control data bit 7 raises `soft_rst` for one cycle. At the following edge every register returns to 0: the controls, slot, mode, data, read data, busy and the memory request.
- R6: An idle data-register write raises `mem_req` with `mem_we`=1, `mem_addr`={mode, slot} and `mem_wdata` equal to the written byte. The data register takes the written byte.
- R7: An idle data-register read raises `mem_req` with `mem_we`=0. It returns the data register's value from before the access. When `mem_ack` arrives, `mem_rdata` is captured into the data register.
- R8: Busy (status bit 0, and `mem_req`) stays high from the accepting edge until the edge at which `mem_ack` is seen, and it is low on the cycle after.
- R9: A data-register access while busy starts nothing and changes neither the data register nor the memory port outputs. A read still returns the data register.
- R10: While a request is pending, `mem_addr`, `mem_we` and `mem_wdata` hold, even if slot or mode is rewritten.
- R11: A `mem_ack` with no pending request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (write wins if both) |
| host_addr | input | 2 | Register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| page_sel | output | 1 | Active data page |
| bb_oe | output | 1 | Backplane bus drive enable |
| lb_oe | output | 1 | Local bus drive enable |
| lclk_oe | output | 1 | Local clock and frame enable |
| clkerr_clr | output | 1 | Clock-error clear pulse |
| syserr_clr | output | 1 | System-error clear pulse |
| soft_rst | output | 1 | Software master reset pulse |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write transfer, 0 = read |
| mem_addr | output | SLOT_W+MODE_W | Memory address {mode, slot} |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 8 | Memory read data, valid with acknowledge |

## Verification
Control outputs, command pulses, read data and memory port outputs all change at the edge that samples the host strobe. The bench therefore drives each strobe at a falling edge and samples at the next falling edge. Command pulses are checked high at that point and low one cycle later. Busy is checked high on the cycle after acceptance and low after the acknowledge edge. The memory model in the bench acknowledges on its third falling edge of a pending request. For that reason a status read issued directly after a data write still sees busy, and the captured word is checked only after the request has dropped.

// File: rtl/tsi_host_pkg.sv
package tsi_host_pkg;
  localparam int HOST_DW = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'b00,
    REG_SLOT = 2'b01,
    REG_MODE = 2'b10,
    REG_DATA = 2'b11
  } host_reg_e;

  // control register bit positions (decoded by host software)
  localparam int BIT_MRST  = 7;
  localparam int BIT_CECLR = 6;
  localparam int BIT_SECLR = 5;
  localparam int BIT_PAGE  = 4;
  localparam int BIT_BBEN  = 3;
  localparam int BIT_LBEN  = 2;
  localparam int BIT_LCEN  = 1;

  typedef struct packed {
    logic page;
    logic bb_en;
    logic lb_en;
    logic lclk_en;
  } ctrl_t;

  typedef struct packed {
    logic mrst;
    logic ceclr;
    logic seclr;
  } cmd_t;
endpackage

// File: rtl/tsi_host_ctrl.sv
module tsi_host_ctrl
  import tsi_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic [HOST_DW-1:1]   wdata,
  output ctrl_t                ctrl_q,
  output cmd_t                 cmd_q
);
  ctrl_t ctrl_d;
  cmd_t  cmd_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cmd_d  = '0;               // commands live for one cycle only
    if (cmd_q.mrst) begin
      ctrl_d = '0;
    end else if (wr_ctrl) begin
      ctrl_d.page    = wdata[BIT_PAGE];
      ctrl_d.bb_en   = wdata[BIT_BBEN];
      ctrl_d.lb_en   = wdata[BIT_LBEN];
      ctrl_d.lclk_en = wdata[BIT_LCEN];
      cmd_d.mrst     = wdata[BIT_MRST];
      cmd_d.ceclr    = wdata[BIT_CECLR];
      cmd_d.seclr    = wdata[BIT_SECLR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmd_q  <= cmd_d;
    end
  end
endmodule

// File: rtl/tsi_host_indirect.sv
module tsi_host_indirect
  import tsi_host_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int MODE_W = 8,
  localparam int AW    = SLOT_W + MODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_clr,
  input  logic               wr_slot,
  input  logic               wr_mode,
  input  logic               wr_data,
  input  logic               rd_data,
  input  logic [HOST_DW-1:0] wdata,
  input  logic               mem_ack,
  input  logic [HOST_DW-1:0] mem_rdata,
  output logic               busy,
  output logic [HOST_DW-1:0] data_q,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [HOST_DW-1:0] mem_wdata
);
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [MODE_W-1:0]  mode_q, mode_d;
  logic [HOST_DW-1:0] data_d, wdat_q, wdat_d;
  logic [AW-1:0]      addr_q, addr_d;
  logic               busy_q, busy_d, we_q, we_d;
  logic               start;

  assign start = (wr_data || rd_data) && !busy_q;

  always_comb begin
    slot_d = slot_q;
    mode_d = mode_q;
    data_d = data_q;
    wdat_d = wdat_q;
    addr_d = addr_q;
    busy_d = busy_q;
    we_d   = we_q;
    if (sw_clr) begin
      slot_d = '0;
      mode_d = '0;
      data_d = '0;
      wdat_d = '0;
      addr_d = '0;
      busy_d = 1'b0;
      we_d   = 1'b0;
    end else begin
      if (wr_slot) slot_d = wdata[SLOT_W-1:0];
      if (wr_mode) mode_d = wdata[MODE_W-1:0];
      if (busy_q && mem_ack) begin
        busy_d = 1'b0;
        if (!we_q) data_d = mem_rdata;
      end else if (start) begin
        busy_d = 1'b1;
        we_d   = wr_data;
        addr_d = {mode_q, slot_q};
        if (wr_data) begin
          data_d = wdata;
          wdat_d = wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      mode_q <= '0;
      data_q <= '0;
      wdat_q <= '0;
      addr_q <= '0;
      busy_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      mode_q <= mode_d;
      data_q <= data_d;
      wdat_q <= wdat_d;
      addr_q <= addr_d;
      busy_q <= busy_d;
      we_q   <= we_d;
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
  import tsi_host_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int MODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [1:0]               host_addr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     page_sel,
  output logic                     bb_oe,
  output logic                     lb_oe,
  output logic                     lclk_oe,
  output logic                     clkerr_clr,
  output logic                     syserr_clr,
  output logic                     soft_rst,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [SLOT_W+MODE_W-1:0] mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic                     mem_ack,
  input  logic [7:0]               mem_rdata
);
  host_reg_e          sel;
  logic               rd_eff;
  ctrl_t              ctrl_q;
  cmd_t               cmd_q;
  logic               busy;
  logic [HOST_DW-1:0] data_q;
  logic [HOST_DW-1:0] rdata_q, rdata_d;

  assign sel    = host_reg_e'(host_addr);
  assign rd_eff = host_rd && !host_wr;

  tsi_host_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (host_wr && sel == REG_CTRL),
    .wdata   (host_wdata[HOST_DW-1:1]),
    .ctrl_q  (ctrl_q),
    .cmd_q   (cmd_q)
  );

  tsi_host_indirect #(.SLOT_W(SLOT_W), .MODE_W(MODE_W)) u_ind (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_clr    (cmd_q.mrst),
    .wr_slot   (host_wr && sel == REG_SLOT),
    .wr_mode   (host_wr && sel == REG_MODE),
    .wr_data   (host_wr && sel == REG_DATA),
    .rd_data   (rd_eff && sel == REG_DATA),
    .wdata     (host_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .data_q    (data_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // registered read-back path
  always_comb begin
    rdata_d = rdata_q;
    if (cmd_q.mrst) begin
      rdata_d = '0;
    end else if (rd_eff) begin
      unique case (sel)
        REG_CTRL: rdata_d = {cmd_q.mrst, cmd_q.ceclr, cmd_q.seclr, ctrl_q.page,
                             ctrl_q.bb_en, ctrl_q.lb_en, ctrl_q.lclk_en, busy};
        REG_DATA: rdata_d = data_q;
        default:  rdata_d = '0;   // slot and mode are write-only
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;
  assign page_sel   = ctrl_q.page;
  assign bb_oe      = ctrl_q.bb_en;
  assign lb_oe      = ctrl_q.lb_en;
  assign lclk_oe    = ctrl_q.lclk_en;
  assign clkerr_clr = cmd_q.ceclr;
  assign syserr_clr = cmd_q.seclr;
  assign soft_rst   = cmd_q.mrst;
endmodule

// File: rtl/tsi_host_port_chk.sv
module tsi_host_port_chk #(
  parameter int SLOT_W = 8,
  parameter int MODE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     host_wr,
  input logic                     host_rd,
  input logic [1:0]               host_addr,
  input logic [7:0]               host_wdata,
  input logic [7:0]               host_rdata,
  input logic                     page_sel,
  input logic                     bb_oe,
  input logic                     lb_oe,
  input logic                     lclk_oe,
  input logic                     clkerr_clr,
  input logic                     syserr_clr,
  input logic                     soft_rst,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic [SLOT_W+MODE_W-1:0] mem_addr,
  input logic [7:0]               mem_wdata,
  input logic                     mem_ack,
  input logic [7:0]               mem_rdata
);
  // R4
  clkerr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkerr_clr |=> !clkerr_clr);
  // R4
  syserr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syserr_clr |=> !syserr_clr);
  // R5
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!soft_rst && !page_sel && !bb_oe && !lb_oe && !lclk_oe && !mem_req
                  && host_rdata == 8'h00));
  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_wr && host_addr == 2'b00) && !soft_rst)
      |=> $stable({page_sel, bb_oe, lb_oe, lclk_oe}));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !soft_rst)
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  // unused by the properties but part of the bound port set
  logic unused_ok;
  assign unused_ok = ^{host_rd, host_wdata, mem_rdata};
endmodule

bind tsi_host_port tsi_host_port_chk #(.SLOT_W(SLOT_W), .MODE_W(MODE_W)) chk_i (.*);

// File: tb/tsi_host_port_tb.sv
`timescale 1ns/1ps
module tsi_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'b00;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        page_sel, bb_oe, lb_oe, lclk_oe, clkerr_clr, syserr_clr, soft_rst;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;

  int errors = 0, checks = 0;
  bit done = 0;
  bit ack_en = 1;
  logic [7:0] last_data = 8'h00;
  logic [7:0] got;

  always #4 clk = ~clk;   // 125 MHz

  tsi_host_port dut_i (.*);

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 50 && mem_req; k++) @(negedge clk);
  endtask

  // memory model: acknowledges on the third falling edge of a pending request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack && ack_en) begin
        mem_ack = 1'b0;
      end else if (ack_en && mem_req) begin
        cnt++;
        if (cnt == 3) begin
          mem_ack = 1'b1;
          mem_rdata = mem_fn(mem_addr);
          cnt = 0;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, s, d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {host_rdata, page_sel, bb_oe, lb_oe, lclk_oe, clkerr_clr, syserr_clr,
                 soft_rst, mem_req}, 0);
    rst_n = 1'b1;

    // R3/R4/R2 sweep of all control values without master reset
    for (int v = 0; v < 128; v++) begin
      host_write(2'd0, 8'(v));
      check("R3", {page_sel, bb_oe, lb_oe, lclk_oe}, v[4:1]);
      check("R4", {clkerr_clr, syserr_clr, soft_rst}, {v[6], v[5], 1'b0});
      host_read(2'd0, got);
      check("R2", got, {3'b000, v[4:1], 1'b0});
      check("R4", {clkerr_clr, syserr_clr}, 0);
    end

    // R2 write-only registers read 0
    host_write(2'd1, 8'hA7);
    host_write(2'd2, 8'h3C);
    host_read(2'd1, got); check("R2", got, 0);
    host_read(2'd2, got); check("R2", got, 0);

    // R6/R8 data writes over address patterns
    for (int i = 0; i < 32; i++) begin
      m = 8'(i * 37 + 5); s = 8'(i * 91 + 3); d = 8'(i) ^ 8'hC3;
      host_write(2'd2, m);
      host_write(2'd1, s);
      host_write(2'd3, d);
      check("R6", {mem_req, mem_we, mem_addr, mem_wdata}, {1'b1, 1'b1, m, s, d});
      host_read(2'd0, got);
      check("R8", got[0], 1'b1);
      wait_idle();
      host_read(2'd0, got);
      check("R8", got[0], 1'b0);
      last_data = d;
    end

    // R7 data reads
    for (int i = 0; i < 16; i++) begin
      m = 8'(i * 13 + 1); s = 8'(i * 29 + 7);
      host_write(2'd2, m);
      host_write(2'd1, s);
      host_read(2'd3, got);
      check("R7", got, last_data);
      check("R7", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, m, s});
      wait_idle();
      last_data = mem_fn({m, s});
      host_read(2'd3, got);
      check("R7", got, last_data);
      wait_idle();
    end

    // R9/R10 accesses and address writes while busy
    ack_en = 0;
    host_write(2'd2, 8'h12);
    host_write(2'd1, 8'h34);
    host_write(2'd3, 8'hA5);
    host_write(2'd1, 8'h77);
    host_write(2'd2, 8'h99);
    check("R10", {mem_req, mem_we, mem_addr, mem_wdata}, {2'b11, 16'h1234, 8'hA5});
    host_write(2'd3, 8'h3C);
    check("R9", {mem_req, mem_we, mem_addr, mem_wdata}, {2'b11, 16'h1234, 8'hA5});
    host_read(2'd3, got);
    check("R9", got, 8'hA5);
    check("R9", {mem_req, mem_we, mem_addr}, {2'b11, 16'h1234});
    ack_en = 1;
    wait_idle();
    last_data = 8'hA5;

    // R11 stray acknowledge
    ack_en = 0;
    @(negedge clk); mem_ack = 1'b1; mem_rdata = 8'hEE;
    @(negedge clk); mem_ack = 1'b0;
    check("R11", mem_req, 1'b0);
    host_read(2'd3, got);
    check("R11", got, last_data);
    ack_en = 1;
    wait_idle();
    last_data = mem_fn(16'h9977);
    host_read(2'd3, got);
    check("R7", got, last_data);
    wait_idle();

    // R5 master reset with a pending request
    host_write(2'd0, 8'h1E);
    ack_en = 0;
    host_write(2'd3, 8'h55);
    check("R5", mem_req, 1'b1);
    host_write(2'd0, 8'h80);
    check("R5", soft_rst, 1'b1);
    @(negedge clk);
    check("R5", {soft_rst, page_sel, bb_oe, lb_oe, lclk_oe, mem_req, host_rdata}, 0);
    host_read(2'd0, got); check("R5", got, 0);
    host_read(2'd3, got); check("R5", got, 0);
    check("R5", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 16'h0000});
    ack_en = 1;
    wait_idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule